// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It supports six operations: two register-to-register arithmetic forms (wrapping add and subtract), a logical OR with an immediate, a word load, a word store and a branch taken when two registers are equal. The core holds the program counter, the next-address logic, a 32-entry by 32-bit register file, the immediate extender, the ALU and the instruction decoder.

Instruction memory and data memory are outside the core. Each one is a word array with a combinational read. The core presents the program counter on `imem_addr` and takes the instruction word back on `imem_rdata` in the same cycle. A load or store presents its effective byte address on `dmem_addr`. A load takes its result from `dmem_rdata` in the same cycle. A store asserts `dmem_we` together with the data on `dmem_wdata`, and the external memory captures that data on the rising edge where the program counter and the register file also update. Instruction fields sit at fixed positions: opcode in bits 31:26, first source register in 25:21, second source or load/ORI target in 20:16, R-type destination in 15:11, shift amount in 10:6, function code in 5:0, and the 16-bit immediate in 15:0.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 (parameter `RESET_PC`). During reset `dmem_we` stays low and no register is written. Register and data memory contents survive a reset.
- R2: Opcode 0x00 with shift amount 0 and function code 0x21 writes the register selected by bits 15:11 with the sum of the two source registers. Function code 0x23 writes that register with the first source minus the second. Both wrap modulo 2^32.
- R3: Opcode 0x0D writes the register selected by bits 20:16 with the first source register ORed with the immediate, extended with zeros.
- R4: Opcode 0x23 drives `dmem_addr` with the first source register plus the sign-extended immediate, and writes the register selected by bits 20:16 with `dmem_rdata`.
- R5: Opcode 0x2B asserts `dmem_we` with `dmem_addr` equal to the first source register plus the sign-extended immediate and `dmem_wdata` equal to the register selected by bits 20:16. No register is written. No other instruction asserts `dmem_we`.
- R6: Opcode 0x04 compares the two source registers. When they are equal, the next PC is PC + 4 + (sign-extended immediate × 4). Otherwise it is PC + 4.
- R7: Every instruction other than a taken branch advances the PC by exactly 4, wrapping modulo 2^32.
- R8: Register 0 always reads as zero. Any write addressed to it, from arithmetic, ORI or a load, is discarded.
- R9: Any other opcode, and an opcode 0x00 word whose function code is not 0x21 or 0x23 or whose shift amount is nonzero, writes no register, does not assert `dmem_we`, and only advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Program counter, byte address of the current instruction |
| imem_rdata | input | 32 | Instruction word read from instruction memory |
| dmem_we | output | 1 | Data memory write enable, asserted by a store |
| dmem_addr | output | 32 | Effective byte address for a load or store |
| dmem_wdata | output | 32 | Word to be stored |
| dmem_rdata | input | 32 | Word read from data memory at `dmem_addr` |

## Verification
The bench runs a reference model in lockstep and checks the PC every cycle. It also checks every store address and stored value, which is how the results of arithmetic, ORI and loads become visible. Directed cases cover these situations. A subtract that wraps to all ones and then an add that wraps back to zero; a core that mishandles the carry would store the wrong word. A load and a store with a negative offset; a core that zero-extends this immediate would access an address 64 KiB away. Writes to register 0 by ORI and by a load, which would later make a store of register 0 non-zero. Taken forward and backward branches with an equal-register test, plus a branch to PC+4 and a not-taken branch; a shift or sign error here would make the PC diverge. Illegal opcodes and malformed R-type words whose destination register is then stored, so that a spurious write shows up. A reset in the middle of the run also shows whether register contents were wrongly cleared.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

  localparam int unsigned XLEN      = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned REG_COUNT = 1 << REG_IDX_W;

  // primary opcodes
  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  // function codes under OPC_REG
  localparam logic [5:0] FN_ADD = 6'h21;
  localparam logic [5:0] FN_SUB = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;
  typedef enum logic {DST_RT, DST_RD} dst_sel_e;

  typedef struct packed {
    logic     reg_wr;
    dst_sel_e dst;
    logic     imm_signed;
    logic     use_imm;
    alu_op_e  alu_op;
    logic     mem_wr;
    logic     from_mem;
    logic     branch;
    logic     illegal;
  } ctl_t;

  // widen a 16-bit immediate either by sign or by zeros
  function automatic logic [XLEN-1:0] ext_imm(input logic [15:0] imm, input logic sgn);
    return {{(XLEN-16){sgn & imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  // word offset scaled to bytes, added to the sequential address
  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] seq_pc,
                                                  input logic [XLEN-1:0] word_off);
    return seq_pc + {word_off[XLEN-3:0], 2'b00};
  endfunction

endpackage

// File: rtl/sc_fetch.sv
`timescale 1ns/1ps
module sc_fetch
  import sc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC   = '0,
  parameter int unsigned     INSN_BYTES = 4
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            take_br,
  input  logic [XLEN-1:0] br_off,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] br_dest
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] pc_seq;

  assign pc_seq  = pc + STEP;
  assign br_dest = branch_dest(pc_seq, br_off);

  always_ff @(posedge clk) begin
    if (rst)          pc <= RESET_PC;
    else if (take_br) pc <= br_dest;
    else              pc <= pc_seq;
  end

endmodule

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctl_t       ctl
);

  always_comb begin
    ctl        = '0;
    ctl.dst    = DST_RT;
    ctl.alu_op = ALU_ADD;
    case (op)
      OPC_REG: begin
        if (shamt == '0 && funct == FN_ADD) begin
          ctl.reg_wr = 1'b1;
          ctl.dst    = DST_RD;
          ctl.alu_op = ALU_ADD;
        end else if (shamt == '0 && funct == FN_SUB) begin
          ctl.reg_wr = 1'b1;
          ctl.dst    = DST_RD;
          ctl.alu_op = ALU_SUB;
        end else begin
          ctl.illegal = 1'b1;
        end
      end
      OPC_ORI: begin
        ctl.reg_wr  = 1'b1;
        ctl.use_imm = 1'b1;
        ctl.alu_op  = ALU_OR;
      end
      OPC_LOAD: begin
        ctl.reg_wr     = 1'b1;
        ctl.use_imm    = 1'b1;
        ctl.imm_signed = 1'b1;
        ctl.from_mem   = 1'b1;
      end
      OPC_STORE: begin
        ctl.use_imm    = 1'b1;
        ctl.imm_signed = 1'b1;
        ctl.mem_wr     = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch     = 1'b1;
        ctl.imm_signed = 1'b1;
        ctl.alu_op     = ALU_SUB;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile
  import sc_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned NRD  = 2,
  localparam int unsigned AW  = $clog2(NREG)
)(
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [XLEN-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][XLEN-1:0] rdata
);

  logic [XLEN-1:0] regs [NREG];

  // entry 0 is never written; its reads are forced to zero below
  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
  end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            eq
);

  assign y  = alu_eval(op, a, b);
  assign eq = (a == b);

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
)(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic        dmem_we,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata
);

  // instruction fields
  logic [5:0]           op_f, funct_f;
  logic [REG_IDX_W-1:0] rs_idx, rt_idx, rd_idx;
  logic [4:0]           shamt_f;
  logic [15:0]          imm16;

  assign {op_f, rs_idx, rt_idx, rd_idx, shamt_f, funct_f} = imem_rdata;
  assign imm16 = imem_rdata[15:0];

  // named internal events, observed by the bound checker
  ctl_t                 ctl;
  logic                 illegal;
  logic                 rf_we;
  logic [REG_IDX_W-1:0] rf_waddr;
  logic [XLEN-1:0]      rf_wdata;
  logic [XLEN-1:0]      rs_val, rt_val;
  logic [XLEN-1:0]      imm_ext, alu_b, alu_y;
  logic                 operands_eq;
  logic                 br_taken;
  logic [XLEN-1:0]      br_target;

  logic [1:0][REG_IDX_W-1:0] rf_raddr;
  logic [1:0][XLEN-1:0]      rf_rdata;

  sc_decode u_dec (
    .op    (op_f),
    .funct (funct_f),
    .shamt (shamt_f),
    .ctl   (ctl)
  );

  assign illegal     = ctl.illegal;
  assign rf_raddr[0] = rs_idx;
  assign rf_raddr[1] = rt_idx;
  assign rs_val      = rf_rdata[0];
  assign rt_val      = rf_rdata[1];

  sc_regfile #(.NREG(REG_COUNT), .NRD(2)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  assign imm_ext = ext_imm(imm16, ctl.imm_signed);
  assign alu_b   = ctl.use_imm ? imm_ext : rt_val;

  sc_alu u_alu (
    .op (ctl.alu_op),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y),
    .eq (operands_eq)
  );

  assign br_taken = ctl.branch & operands_eq;

  sc_fetch #(.RESET_PC(RESET_PC), .INSN_BYTES(4)) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .take_br (br_taken),
    .br_off  (imm_ext),
    .pc      (imem_addr),
    .br_dest (br_target)
  );

  // write-back and memory side; reset suppresses every write
  assign rf_we      = ctl.reg_wr & ~rst;
  assign rf_waddr   = (ctl.dst == DST_RD) ? rd_idx : rt_idx;
  assign rf_wdata   = ctl.from_mem ? dmem_rdata : alu_y;
  assign dmem_we    = ctl.mem_wr & ~rst;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;

endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
)(
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic        dmem_we,
  input logic        rf_we,
  input logic        br_taken,
  input logic [31:0] br_target,
  input logic        illegal,
  input logic [4:0]  rs_idx,
  input logic [31:0] rs_val
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: a reset edge leaves the PC at its reset value; nothing is written while reset is held
  always @(negedge clk) begin
    if (rst_q) a_reset_pc_r1: assert (imem_addr == RESET_PC);
    if (rst)   a_reset_quiet_r1: assert (!dmem_we && !rf_we);
  end

  p_seq_pc_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(br_taken)) |-> imem_addr == $past(imem_addr) + 32'd4);

  p_branch_pc_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_taken)) |-> imem_addr == $past(br_target));

  p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (!rf_we && !br_taken));

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == 5'd0) |-> rs_val == 32'd0);

  p_nop_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!dmem_we && !rf_we && !br_taken));

endmodule

bind sc_core sc_core_chk #(.RESET_PC(RESET_PC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .dmem_we   (dmem_we),
  .rf_we     (rf_we),
  .br_taken  (br_taken),
  .br_target (br_target),
  .illegal   (illegal),
  .rs_idx    (rs_idx),
  .rs_val    (rs_val)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;

  localparam int unsigned WORDS    = 256;
  localparam int unsigned CYCLES   = 4000;
  localparam int unsigned RESET_AT = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [WORDS];
  logic [31:0] dmem [WORDS];

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  sc_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference machine state
  logic [31:0] m_reg [32];
  string       m_tag [32];
  logic [31:0] m_mem [WORDS];
  logic [31:0] m_pc;
  string       pc_tag;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h (pc %h)", req, act, exp, m_pc);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input int sh, input int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] rand_insn();
    int k, a, b, c;
    logic [5:0] op;
    k = int'($urandom_range(0, 9));
    a = int'($urandom_range(0, 31));
    b = int'($urandom_range(0, 31));
    c = int'($urandom_range(0, 31));
    case (k)
      0, 1: return enc_r(a, b, c, 0, 'h21);
      2:    return enc_r(a, b, c, 0, 'h23);
      3:    return enc_i(6'h0D, a, b, int'($urandom_range(0, 65535)));
      4:    return enc_i(6'h23, a, b, int'($urandom_range(0, 65535)));
      5, 6: return enc_i(6'h2B, a, b, int'($urandom_range(0, 65535)));
      7:    return enc_i(6'h04, a, ($urandom_range(0, 1) == 1) ? a : b,
                         int'($urandom_range(0, 6)));
      8: begin
        op = 6'($urandom_range(0, 63));
        if (op inside {6'h00, 6'h0D, 6'h23, 6'h2B, 6'h04}) op = 6'h3F;
        return {op, 26'($urandom)};
      end
      default: begin
        if ($urandom_range(0, 1) == 1) return enc_r(a, b, c, 1 + int'($urandom_range(0, 30)), 'h21);
        return enc_r(a, b, c, 0, 'h20);
      end
    endcase
  endfunction

  task automatic put(input logic [4:0] idx, input logic [31:0] val, input string t);
    if (idx != 5'd0) begin
      m_reg[idx] = val;
      m_tag[idx] = t;
    end
  endtask

  // compare current outputs with the model, then commit the instruction in the model
  task automatic model_step();
    logic [31:0] w, a, b, ea, imm_s, imm_z, nxt;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh;
    bit          bad, is_st;
    #1;
    w  = imem[m_pc[9:2]];
    op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; sh = w[10:6]; fn = w[5:0];
    a  = m_reg[rs];
    b  = m_reg[rt];
    imm_s = 32'($signed(w[15:0]));
    imm_z = {16'h0000, w[15:0]};
    ea    = a + imm_s;
    bad   = !((op == 6'h00 && sh == 5'd0 && (fn == 6'h21 || fn == 6'h23)) ||
              (op inside {6'h0D, 6'h23, 6'h2B, 6'h04}));
    is_st = (op == 6'h2B);

    check(pc_tag, imem_addr, m_pc);
    check(bad ? "R9" : "R5", 32'(dmem_we), 32'(is_st));
    if (is_st) begin
      check("R5", dmem_addr, ea);
      check({"R5/", m_tag[rt]}, dmem_wdata, b);
    end
    if (op == 6'h23 && !bad) check("R4", dmem_addr, ea);

    nxt    = m_pc + 32'd4;
    pc_tag = "R7";
    if (bad) pc_tag = "R9";
    else begin
      case (op)
        6'h00: put(rd, (fn == 6'h21) ? a + b : a - b, "R2");
        6'h0D: put(rt, a | imm_z, "R3");
        6'h23: put(rt, m_mem[ea[9:2]], "R4");
        6'h2B: m_mem[ea[9:2]] = b;
        6'h04: begin
          pc_tag = "R6";
          if (a == b) nxt = m_pc + 32'd4 + (imm_s << 2);
        end
        default: ;
      endcase
    end
    m_pc = nxt;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(64'd200000 * 64'd10);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));

    for (int i = 0; i < 32; i++) begin
      m_reg[i] = '0;
      m_tag[i] = (i == 0) ? "R8" : "R3";
    end
    for (int i = 0; i < int'(WORDS); i++) begin
      m_mem[i] = $urandom;
      dmem[i]  = m_mem[i];
    end

    // directed program
    imem[0] = enc_i(6'h2B, 0, 0, 'h40);                  // store during reset (R1), r0 value (R8)
    for (int k = 1; k < 32; k++) imem[k] = enc_i(6'h0D, 0, k, int'($urandom_range(0, 65535)));
    imem[32] = enc_i(6'h0D, 0, 0, 'hFFFF);               // R8: ORI into r0 discarded
    imem[33] = enc_i(6'h2B, 0, 0, 8);
    imem[34] = enc_i(6'h0D, 0, 4, 1);                    // r4 = 1
    imem[35] = enc_r(0, 4, 3, 0, 'h23);                  // R2: r3 = 0 - 1 wraps
    imem[36] = enc_r(3, 4, 5, 0, 'h21);                  // R2: r5 = all ones + 1 wraps to 0
    imem[37] = enc_i(6'h2B, 0, 3, 12);
    imem[38] = enc_i(6'h2B, 0, 5, 16);
    imem[39] = enc_i(6'h0D, 0, 7, 'h100);
    imem[40] = enc_i(6'h2B, 7, 3, -4);                   // R5: negative offset
    imem[41] = enc_i(6'h23, 7, 8, -4);                   // R4: negative offset
    imem[42] = enc_i(6'h2B, 0, 8, 20);
    imem[43] = enc_i(6'h04, 4, 4, 1);                    // R6: taken, skips next
    imem[44] = enc_i(6'h2B, 0, 4, 24);
    imem[45] = enc_i(6'h04, 4, 3, 5);                    // R6: not taken
    imem[46] = {6'h3F, 26'h1234567};                     // R9: unknown opcode
    imem[47] = enc_r(4, 4, 9, 0, 'h20);                  // R9: unknown function code
    imem[48] = enc_r(4, 4, 9, 1, 'h21);                  // R9: nonzero shift amount
    imem[49] = enc_i(6'h2B, 0, 9, 28);                   // r9 must still hold its ORI value
    imem[50] = enc_i(6'h04, 0, 0, 2);                    // R6: to 53
    imem[51] = enc_i(6'h2B, 0, 4, 32);
    imem[52] = enc_i(6'h04, 0, 0, 2);                    // to 55
    imem[53] = enc_i(6'h04, 0, 0, -2);                   // R6: backward to 52
    imem[54] = enc_i(6'h2B, 0, 4, 36);
    imem[55] = enc_i(6'h2B, 0, 5, 40);
    imem[56] = enc_i(6'h23, 0, 0, 12);                   // R8: load into r0 discarded
    imem[57] = enc_i(6'h2B, 0, 0, 44);
    imem[58] = enc_i(6'h04, 0, 0, 0);                    // R6: taken to PC+4
    for (int i = 59; i < int'(WORDS); i++) imem[i] = rand_insn();

    // R1: reset state
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", imem_addr, 32'h0);
    check("R1", 32'(dmem_we), 32'h0);
    rst    = 1'b0;
    m_pc   = '0;
    pc_tag = "R1";

    for (int cyc = 0; cyc < int'(CYCLES); cyc++) begin
      if (cyc == int'(RESET_AT)) begin
        rst = 1'b1;
        @(negedge clk);
        #1;
        check("R1", imem_addr, 32'h0);
        check("R1", 32'(dmem_we), 32'h0);
        rst    = 1'b0;
        m_pc   = '0;
        pc_tag = "R1";
      end
      model_step();
      @(negedge clk);
    end

    summary();
    $finish;
  end

endmodule